// File: doc/BRIEF.md
# Programmable Delay Line Controller

This block delays a stream of words by a programmable number of clock cycles. It contains a line buffer: a memory with a write pointer and a read pointer, each of which can be returned to address zero. It also contains a sequencer that drives the pointer resets and the read gating of that buffer. The delay comes only from where in time the pointer resets and the read gaps fall. No counter or shift register sits on the data path. Write enable is held active at all times. One clock runs both sides.

A single-cycle `start` pulse samples the requested length and the method code. The length is clamped into the legal window. The sequencer then builds the delay in one of three ways:
- periodic: both pointers are reset together every n cycles;
- staggered: the read pointer is reset n cycles after the write pointer;
- held: both pointers are reset together and reading is then paused for n cycles.

`valid` rises once the outputs carry delayed input. It stays high until the next `start` or reset.

Top module: `linedly_top`

## Requirements
- R1: After synchronous reset, `valid` and `len_err` are low.
- R2: While `valid` is high, `dout` after clock edge j equals the `din` sampled at edge j-n, where n is the effective length latched at the last `start`.
- R3: With `mode_sel` = 0 (periodic), both pointers are reset at the start edge and on every n-th edge after it.
- R4: With `mode_sel` = 1 (staggered), the write pointer is reset at the start edge and the read pointer is reset at the edge n cycles later.
- R5: With `mode_sel` = 2 (held), both pointers are reset at the start edge and reads are inhibited for the next n edges. `valid` first reads high after edge start+n+1.
- R6: With `mode_sel` 0 or 1, `valid` first reads high after edge start+n. Once high it stays high until the next `start` or reset. The edge that samples `start` drives it low.
- R7: A requested length below MIN_N is raised to MIN_N, and one above DEPTH is lowered to DEPTH. `len_err` then reads 1 after the start edge, and 0 for a legal length. Length, method and `len_err` change only on a `start` edge; `n_req` and `mode_sel` are ignored at all other edges.
- R8: `mode_sel` = 3 behaves exactly as `mode_sel` = 0.
- R9: A `start` during a run restarts the sequence with the newly sampled length and method.
- R10: n = DEPTH is delivered exactly. On the cycle where a cell is both read and written, the read returns the old content.
- R11: While reads are inhibited and no read reset occurs, `dout` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that samples length and method and restarts the sequence |
| n_req | input | $clog2(DEPTH+1) | Requested delay length in cycles |
| mode_sel | input | 2 | Delay method: 0 periodic, 1 staggered, 2 held, 3 same as 0 |
| din | input | WIDTH | Input word, sampled every edge |
| dout | output | WIDTH | Delayed word, registered |
| valid | output | 1 | `dout` carries delayed input |
| len_err | output | 1 | Last sampled length lay outside MIN_N..DEPTH |

## Verification
Two situations are hard to reach. The first is a full-depth delay, where the write and read pointers land on the same cell on the same edge. The bench drives this with both a clamped oversize request and an exact DEPTH request, so the read-before-write ordering decides every compared word.

The second is proving that `n_req` and `mode_sel` have no effect mid-run. The bench drives random values on both pins every cycle between start pulses. It then checks that the data alignment and `len_err` still follow the values latched at start.

Restarts are issued before a run has filled, so that no stale output can raise `valid`.

// File: rtl/linedly_pkg.sv
package linedly_pkg;
  typedef enum logic [1:0] {
    DM_PERIODIC = 2'd0,
    DM_STAGGER  = 2'd1,
    DM_HOLD     = 2'd2
  } dly_mode_e;

  function automatic dly_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    decode_mode = DM_STAGGER;
      2'd2:    decode_mode = DM_HOLD;
      default: decode_mode = DM_PERIODIC;
    endcase
  endfunction
endpackage

// File: rtl/linedly_buf.sv
module linedly_buf #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_rst,
  input  logic             rd_en,
  output logic [WIDTH-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [AW-1:0]    waddr, raddr;
  logic             do_wr, do_rd;

  // A reset cycle still moves data, at address zero.
  assign waddr = wr_rst ? '0 : wptr_q;
  assign raddr = rd_rst ? '0 : rptr_q;
  assign do_wr = wr_rst | wr_en;
  assign do_rd = rd_rst | rd_en;

  always_ff @(posedge clk) begin
    if (do_wr) mem[waddr] <= din;
  end

  // Read-first: a same-cycle write to raddr is not seen here.
  always_ff @(posedge clk) begin
    if (rst)        dout <= '0;
    else if (do_rd) dout <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_wr) wptr_q <= (waddr == LAST) ? '0 : waddr + AW'(1);
      if (do_rd) rptr_q <= (raddr == LAST) ? '0 : raddr + AW'(1);
    end
  end
endmodule

// File: rtl/linedly_seq.sv
module linedly_seq
  import linedly_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int MIN_N = 15
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [$clog2(DEPTH+1)-1:0]   n_req,
  input  logic [1:0]                   mode_sel,
  output logic                         wr_rst,
  output logic                         rd_rst,
  output logic                         rd_en,
  output logic                         valid,
  output logic                         len_err
);
  localparam int NW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(DEPTH + 2);
  localparam logic [NW-1:0] LO = NW'(MIN_N);
  localparam logic [NW-1:0] HI = NW'(DEPTH);

  dly_mode_e     mode_q;
  logic [NW-1:0] n_q, n_clamp, ph_q;
  logic [CW-1:0] cnt_q, n_ext, thr;
  logic          run_q, bad_len;

  assign bad_len = (n_req < LO) || (n_req > HI);
  assign n_clamp = (n_req < LO) ? LO : ((n_req > HI) ? HI : n_req);
  assign n_ext   = CW'(n_q);
  assign thr     = (mode_q == DM_HOLD) ? n_ext + CW'(1) : n_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      mode_q  <= DM_PERIODIC;
      n_q     <= LO;
      cnt_q   <= '0;
      ph_q    <= '0;
      valid   <= 1'b0;
      len_err <= 1'b0;
    end else if (start) begin
      run_q   <= 1'b1;
      mode_q  <= decode_mode(mode_sel);
      n_q     <= n_clamp;
      len_err <= bad_len;
      cnt_q   <= CW'(1);
      ph_q    <= NW'(1);
      valid   <= 1'b0;
    end else if (run_q) begin
      if (cnt_q <= n_ext) cnt_q <= cnt_q + CW'(1);
      ph_q <= (ph_q == n_q - NW'(1)) ? '0 : ph_q + NW'(1);
      if (cnt_q == thr) valid <= 1'b1;
    end
  end

  always_comb begin
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    rd_en  = 1'b1;
    if (start) begin
      wr_rst = 1'b1;
      rd_rst = 1'b1;
    end else if (run_q) begin
      case (mode_q)
        DM_STAGGER: rd_rst = (cnt_q == n_ext);
        DM_HOLD:    rd_en  = (cnt_q > n_ext);
        default: begin
          wr_rst = (ph_q == '0);
          rd_rst = (ph_q == '0);
        end
      endcase
    end
  end
endmodule

// File: rtl/linedly_top.sv
module linedly_top #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  parameter int MIN_N = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [$clog2(DEPTH+1)-1:0] n_req,
  input  logic [1:0]                 mode_sel,
  input  logic [WIDTH-1:0]           din,
  output logic [WIDTH-1:0]           dout,
  output logic                       valid,
  output logic                       len_err
);
  logic wr_rst_w, rd_rst_w, rd_en_w;

  linedly_seq #(.DEPTH(DEPTH), .MIN_N(MIN_N)) seq_i (
    .clk(clk), .rst(rst), .start(start), .n_req(n_req), .mode_sel(mode_sel),
    .wr_rst(wr_rst_w), .rd_rst(rd_rst_w), .rd_en(rd_en_w),
    .valid(valid), .len_err(len_err)
  );

  linedly_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) buf_i (
    .clk(clk), .rst(rst), .wr_rst(wr_rst_w), .wr_en(1'b1), .din(din),
    .rd_rst(rd_rst_w), .rd_en(rd_en_w), .dout(dout)
  );
endmodule

// File: rtl/linedly_chk.sv
module linedly_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             valid,
  input logic             len_err,
  input logic [WIDTH-1:0] dout,
  input logic             rd_en,
  input logic             rd_rst
);
  // R1
  valid_after_reset_chk: assert property (@(posedge clk) rst |=> !valid);
  // R6
  valid_cleared_by_start_chk: assert property (@(posedge clk) disable iff (rst) start |=> !valid);
  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst) (valid && !start) |=> valid);
  // R7
  err_only_on_start_chk: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(len_err));
  // R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst) (!rd_en && !rd_rst) |=> $stable(dout));
  // R5
  reads_open_when_valid_chk: assert property (@(posedge clk) disable iff (rst) (valid && !start) |-> rd_en);
endmodule

bind linedly_top linedly_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .start(start), .valid(valid), .len_err(len_err),
  .dout(dout), .rd_en(rd_en_w), .rd_rst(rd_rst_w)
);

// File: tb/linedly_tb.sv
module linedly_top_tb_top;
  localparam int WIDTH = 16;
  localparam int DEPTH = 256;
  localparam int MIN_N = 15;
  localparam int NW    = $clog2(DEPTH + 1);

  typedef struct { int e; logic [WIDTH-1:0] d; } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [NW-1:0]    n_req = '0;
  logic [1:0]       mode_sel = '0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             valid, len_err;

  int    checks = 0, errors = 0, edge_no = 0;
  int    start_edge = 32'h3fff_ffff, exp_n = 0, first_valid = 0, mode_cur = 0;
  bit    finished = 1'b0;
  logic [WIDTH-1:0] prev_dout = '0;
  item_t q[$];

  linedly_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .MIN_N(MIN_N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .n_req(n_req), .mode_sel(mode_sel),
    .din(din), .dout(dout), .valid(valid), .len_err(len_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) edge_no <= edge_no + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_no);
    end
  endtask

  // Driver: one run, pushing each word sampled by the design into the scoreboard.
  task automatic run(input int code, input int nreq, input int cycles, input int n_eff,
                     input bit err_exp, input string req);
    @(posedge clk); #2;
    start = 1'b1; mode_sel = 2'(code); n_req = NW'(nreq); din = WIDTH'($urandom);
    start_edge  = edge_no + 1;
    exp_n       = n_eff;
    mode_cur    = (code == 2) ? 2 : 0;
    first_valid = start_edge + n_eff + ((code == 2) ? 1 : 0);
    q.push_back('{start_edge, din});
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #2;
      if (i == 0) chk(len_err == err_exp, {req, " R7 len_err"}, int'(len_err), int'(err_exp));
      start = 1'b0;
      n_req = NW'($urandom);
      mode_sel = 2'($urandom);
      din = WIDTH'($urandom);
      q.push_back('{edge_no + 1, din});
    end
    // R7: mid-run pin changes left the flag untouched
    chk(len_err == err_exp, "R7 len_err held", int'(len_err), int'(err_exp));
  endtask

  // Monitor: compares outputs of the last edge against the scoreboard.
  always @(negedge clk) begin
    if (!rst && edge_no >= start_edge) begin
      automatic int j = edge_no;
      automatic bit vexp = (j >= first_valid);
      automatic string vreq = (mode_cur == 2) ? "R5 valid" : "R6 valid";
      chk(valid == vexp, vreq, int'(valid), int'(vexp));
      if (valid) begin
        while (q.size() > 0 && q[0].e < j - exp_n) void'(q.pop_front());
        if (q.size() > 0 && q[0].e == j - exp_n)
          chk(dout == q[0].d, "R2 data", int'(dout), int'(q[0].d));
        else
          chk(1'b0, "R2 missing item", j, j - exp_n);
      end
      if (mode_cur == 2 && j > start_edge && j <= start_edge + exp_n)
        chk(dout == prev_dout, "R11 hold", int'(dout), int'(prev_dout));
      prev_dout = dout;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    chk(len_err == 1'b0, "R1 len_err", int'(len_err), 0);
    run(0, 20, 100, 20, 1'b0, "R3");
    run(1, 37, 120, 37, 1'b0, "R4");
    run(2, 15, 100, 15, 1'b0, "R5");
    run(3, 22, 80, 22, 1'b0, "R8");
    run(1, 3, 60, MIN_N, 1'b1, "R7 low");
    run(0, 1000, 600, DEPTH, 1'b1, "R10 clamp");
    run(2, DEPTH, 600, DEPTH, 1'b0, "R10 exact");
    run(1, 50, 30, 50, 1'b0, "R9 first");
    run(0, 18, 80, 18, 1'b0, "R9 restart");
    run(2, 40, 30, 40, 1'b0, "R9 first");
    run(1, 16, 70, 16, 1'b0, "R9 restart");
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule